// File: doc/BRIEF.md
# Byte-Wide SPI Slave with Double-Buffered Transmit

This block is the slave side of a byte-oriented SPI link, built entirely in the system clock domain. The serial clock, data-in and select pins are each passed through a two-flop synchronizer, and edges of the serial clock are found by comparing the synchronized value with its previous sample. The external master always drives the serial clock. The slave never starts a transfer on its own. The bit order is fixed to MSB first, in SPI mode 0: input data is sampled on the rising SCK edge and output data changes on the falling SCK edge.

On the host side there is a register-style interface. A write strobe places a byte in a transmit holding buffer. When the transmit shift register is empty and no byte is half shifted, the held byte moves into it straight away. Otherwise the handoff waits until the final rising SCK edge of the byte in progress. After each full byte, the received value is copied to a receive buffer and a sticky completion flag is raised. The flag stays set until the host pulses a clear input.

A two-bit select-mode input chooses between 3-wire operation, where the select pin is ignored, and 4-wire operation, where the select pin gates the slave and its falling edge resets the bit counter.

Top module: `spi_byte_slave`

## Requirements
- R1: After reset, `done_flag` is 0, `rx_data` is 0x00, and with `nss_i` high in 4-wire mode `miso_oe_o` is 0 and `miso_o` is 1.
- R2: While the slave is selected, MOSI is sampled on each rising SCK edge, MSB first. After the 8th rising edge of a byte, `rx_data` holds the received byte and `done_flag` is set.
- R3: `done_flag` remains 1 until `flag_clr` is pulsed. A completion in the same cycle as a clear wins over the clear.
- R4: The byte in the transmit shift register appears on `miso_o` MSB first. Bit 7 is present before the first rising SCK edge, and each following bit is presented after a falling SCK edge.
- R5: When the transmit shift register is empty, the slave sends 0xFF (`miso_o` held at 1).
- R6: A `tx_wr` places `tx_data` in a holding buffer. The held byte moves into an empty shift register while the bit count is 0. If the shift register is occupied, the held byte is loaded at the last rising SCK edge of the byte in progress, so consecutive bytes follow with no gap.
- R7: In 4-wire mode with `nss_i` high, SCK edges are ignored (no bit counted, no flag, `rx_data` unchanged) and `miso_oe_o` is 0.
- R8: In 4-wire mode, a falling edge on `nss_i` resets the bit counter, so a byte cut short is discarded and the next byte is framed from its first bit.
- R9: In 3-wire mode (`nss_mode` = 2'b00), `nss_i` has no effect and the slave is selected, with `miso_oe_o` = 1, whenever `enable` is 1.
- R10: With `enable` = 0, SCK edges are ignored, `done_flag` and `rx_data` do not change, and `miso_oe_o` is 0.
- R11: `nss_mode` = 2'b01 selects 4-wire mode (the default). The values 2'b10 and 2'b11 also behave as 4-wire mode.
- R12: `rx_data` changes only when a byte completes and otherwise holds the most recently completed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Slave enable |
| nss_mode | input | 2 | Select mode: 00 = 3-wire, other values = 4-wire |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| nss_i | input | 1 | Active-low slave select (4-wire mode) |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Drive enable for the MISO pad |
| tx_wr | input | 1 | Write strobe into the transmit holding buffer |
| tx_data | input | 8 | Byte to transmit |
| flag_clr | input | 1 | Clears the completion flag |
| rx_data | output | 8 | Most recently received byte |
| done_flag | output | 1 | Sticky byte-completion flag |

## Verification
Some behaviour is checked by the assertions on every cycle:
- a completed byte always raises the flag on the next cycle;
- the flag never drops without a clear;
- the receive buffer never moves outside a byte completion;
- the bit counter stays frozen while the slave is deselected and returns to zero after a select falling edge;
- a waiting held byte always enters the shift register at the final edge of the byte in progress;
- the pad driver is off while the block is disabled.

Other behaviour needs whole transfers and is shown only by the bench scenarios:
- the MSB-first bit order in both directions;
- the 0xFF fill sent when no byte is loaded;
- back-to-back bytes with no gap;
- a write made in the middle of a byte;
- recovery after an aborted byte;
- how each mode value treats the select pin.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;

  // Select-mode encodings
  localparam logic [1:0] SEL_THREE_WIRE = 2'b00;
  localparam logic [1:0] SEL_FOUR_WIRE  = 2'b01;

  function automatic logic is_three_wire(input logic [1:0] mode);
    return mode == SEL_THREE_WIRE;
  endfunction

  function automatic logic edge_up(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  function automatic logic edge_down(input logic cur, input logic prev);
    return ~cur & prev;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      for (int s = STAGES - 1; s > 0; s--) stg[s] <= stg[s-1];
      stg[0] <= din;
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_rx_engine.sv
module spi_rx_engine #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sck_rise,
  input  logic              mosi,
  input  logic              cnt_clr,
  input  logic              flag_clr,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              byte_end,
  output logic [DATA_W-1:0] rx_data,
  output logic              done_flag
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] rx_sr;
  logic              take_bit;

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] cur,
                                                 input logic bit_in);
    return {cur[DATA_W-2:0], bit_in};
  endfunction

  assign take_bit = active & sck_rise & ~cnt_clr;
  assign byte_end = take_bit & (bit_cnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
    end else if (cnt_clr) begin
      bit_cnt <= '0;
    end else if (take_bit) begin
      rx_sr   <= shift_in(rx_sr, mosi);
      bit_cnt <= byte_end ? '0 : bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
    end else if (byte_end) begin
      rx_data <= shift_in(rx_sr, mosi);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
    end else if (byte_end) begin
      done_flag <= 1'b1;
    end else if (flag_clr) begin
      done_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_tx_path.sv
module spi_tx_path #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              byte_end,
  input  logic              shift_fall,
  output logic              tx_bit,
  output logic              sr_full,
  output logic              hold_v
);
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] tx_sr;
  logic              idle_slot;
  logic              load_now;

  assign idle_slot = ~sr_full & (bit_cnt == '0);
  assign load_now  = hold_v & (byte_end | idle_slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      hold_v <= 1'b0;
    end else begin
      if (tx_wr) hold_q <= tx_data;
      if (tx_wr)         hold_v <= 1'b1;
      else if (load_now) hold_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '1;
      sr_full <= 1'b0;
    end else if (load_now) begin
      tx_sr   <= hold_q;
      sr_full <= 1'b1;
    end else if (byte_end) begin
      tx_sr   <= '1;
      sr_full <= 1'b0;
    end else if (shift_fall) begin
      tx_sr <= {tx_sr[DATA_W-2:0], 1'b1};
    end
  end

  assign tx_bit = sr_full ? tx_sr[DATA_W-1] : 1'b1;
endmodule

// File: rtl/spi_byte_slave.sv
module spi_byte_slave #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        nss_mode,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              nss_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              done_flag
);
  import spi_slave_pkg::*;

  localparam int unsigned CNT_W = $clog2(DATA_W);

  logic [2:0]       pins_s;
  logic             sck_s, mosi_s, nss_s;
  logic             sck_prev, nss_prev;
  logic             sck_rise, sck_fall;
  logic             three_wire;
  logic             selected;
  logic             nss_fall;
  logic [CNT_W-1:0] bit_cnt;
  logic             byte_end;
  logic             shift_fall;
  logic             sr_full;
  logic             hold_v;
  logic             tx_bit;

  spi_pin_sync #(
    .W(3), .STAGES(SYNC_DEPTH), .RST_VAL(3'b100)
  ) i_sync (
    .clk (clk),
    .rst_n(rst_n),
    .din ({nss_i, mosi_i, sck_i}),
    .dout(pins_s)
  );

  assign {nss_s, mosi_s, sck_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      nss_prev <= 1'b1;
    end else begin
      sck_prev <= sck_s;
      nss_prev <= nss_s;
    end
  end

  assign sck_rise   = edge_up(sck_s, sck_prev);
  assign sck_fall   = edge_down(sck_s, sck_prev);
  assign three_wire = is_three_wire(nss_mode);
  assign selected   = enable & (three_wire | ~nss_s);
  assign nss_fall   = enable & ~three_wire & edge_down(nss_s, nss_prev);

  spi_rx_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (selected),
    .sck_rise (sck_rise),
    .mosi     (mosi_s),
    .cnt_clr  (nss_fall),
    .flag_clr (flag_clr),
    .bit_cnt  (bit_cnt),
    .byte_end (byte_end),
    .rx_data  (rx_data),
    .done_flag(done_flag)
  );

  assign shift_fall = selected & sck_fall & (bit_cnt != '0) & ~nss_fall;

  spi_tx_path #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_wr     (tx_wr),
    .tx_data   (tx_data),
    .bit_cnt   (bit_cnt),
    .byte_end  (byte_end),
    .shift_fall(shift_fall),
    .tx_bit    (tx_bit),
    .sr_full   (sr_full),
    .hold_v    (hold_v)
  );

  assign miso_o    = tx_bit;
  assign miso_oe_o = selected;
endmodule

// File: rtl/spi_byte_slave_chk.sv
module spi_byte_slave_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              flag_clr,
  input logic              tx_wr,
  input logic              byte_end,
  input logic              nss_fall,
  input logic              selected,
  input logic              hold_v,
  input logic              sr_full,
  input logic              done_flag,
  input logic              miso_oe_o,
  input logic [DATA_W-1:0] rx_data,
  input logic [CNT_W-1:0]  bit_cnt
);
  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end |=> done_flag);

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !flag_clr) |=> done_flag);

  // R12
  rx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_end |=> $stable(rx_data));

  // R7
  cnt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !selected |=> $stable(bit_cnt));

  // R8
  cnt_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nss_fall |=> (bit_cnt == '0));

  // R6
  handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && hold_v && !tx_wr) |=> (sr_full && !hold_v));

  // R10
  oe_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !miso_oe_o);
endmodule

bind spi_byte_slave spi_byte_slave_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .flag_clr (flag_clr),
  .tx_wr    (tx_wr),
  .byte_end (byte_end),
  .nss_fall (nss_fall),
  .selected (selected),
  .hold_v   (hold_v),
  .sr_full  (sr_full),
  .done_flag(done_flag),
  .miso_oe_o(miso_oe_o),
  .rx_data  (rx_data),
  .bit_cnt  (bit_cnt)
);

// File: tb/test_spi_byte_slave.sv
module test_spi_byte_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 8;

  typedef struct packed {
    logic [1:0] mode;
    logic       nss;
    logic       has_tx;
    logic [7:0] mosi;
    logic [7:0] tx;
    logic       exp_flag;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{2'b01, 1'b0, 1'b1, 8'hA5, 8'h3C, 1'b1},  // R2 R4 4-wire normal
    '{2'b01, 1'b0, 1'b0, 8'h5A, 8'h00, 1'b1},  // R5 empty -> FF
    '{2'b01, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b0},  // R7 deselected
    '{2'b00, 1'b1, 1'b1, 8'h81, 8'hC3, 1'b1},  // R9 3-wire ignores NSS
    '{2'b10, 1'b1, 1'b0, 8'h33, 8'h00, 1'b0},  // R11 10 is 4-wire
    '{2'b11, 1'b0, 1'b1, 8'h0F, 8'hF0, 1'b1},  // R11 11 is 4-wire
    '{2'b00, 1'b0, 1'b1, 8'h7E, 8'h01, 1'b1},  // R9
    '{2'b01, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b1}   // R2 R4
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b1;
  logic [1:0] nss_mode = 2'b01;
  logic       sck_i = 1'b0;
  logic       mosi_i = 1'b0;
  logic       nss_i = 1'b1;
  logic       miso_o, miso_oe_o;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       flag_clr = 1'b0;
  logic [7:0] rx_data;
  logic       done_flag;

  int  checks = 0;
  int  failures = 0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_byte_slave i_spi_byte_slave (
    .clk(clk), .rst_n(rst_n), .enable(enable), .nss_mode(nss_mode),
    .sck_i(sck_i), .mosi_i(mosi_i), .nss_i(nss_i),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .tx_wr(tx_wr), .tx_data(tx_data), .flag_clr(flag_clr),
    .rx_data(rx_data), .done_flag(done_flag)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_tx(input logic [7:0] d);
    @(negedge clk);
    tx_data = d;
    tx_wr   = 1'b1;
    @(negedge clk);
    tx_wr   = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  // Master side: nbits bits MSB first, mode 0, optional host write after bit 4
  task automatic spi_xfer(input logic [7:0] mo, input int nbits,
                          input logic mid_wr, input logic [7:0] mid_data,
                          output logic [7:0] mi, output logic oe_seen);
    mi = 8'h00;
    oe_seen = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      mosi_i = mo[7-i];
      wait_clk(HALF_SCK);
      mi[7-i] = miso_o;
      oe_seen = miso_oe_o;
      if (mid_wr && i == 4) write_tx(mid_data);
      sck_i = 1'b1;
      wait_clk(HALF_SCK);
      sck_i = 1'b0;
    end
    wait_clk(HALF_SCK);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] mi;
    logic       oe;
    logic [7:0] prev_rx;

    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    // R1 reset state
    chk("R1 flag", {7'd0, done_flag}, 8'h00);
    chk("R1 rx_data", rx_data, 8'h00);
    chk("R1 oe", {7'd0, miso_oe_o}, 8'h00);
    chk("R1 R5 miso idle", {7'd0, miso_o}, 8'h01);

    // Table-driven transfers
    prev_rx = 8'h00;
    for (int v = 0; v < NVEC; v++) begin
      nss_mode = VEC[v].mode;
      wait_clk(2);
      if (VEC[v].has_tx) write_tx(VEC[v].tx);
      nss_i = VEC[v].nss;
      wait_clk(6);
      spi_xfer(VEC[v].mosi, 8, 1'b0, 8'h00, mi, oe);
      chk($sformatf("R2 R3 flag vec%0d", v), {7'd0, done_flag}, {7'd0, VEC[v].exp_flag});
      if (VEC[v].exp_flag) begin
        chk($sformatf("R2 rx vec%0d", v), rx_data, VEC[v].mosi);
        chk($sformatf("R4 R5 miso vec%0d", v), mi, VEC[v].has_tx ? VEC[v].tx : 8'hFF);
        chk($sformatf("R9 R11 oe vec%0d", v), {7'd0, oe}, 8'h01);
        prev_rx = VEC[v].mosi;
      end else begin
        chk($sformatf("R7 R12 rx kept vec%0d", v), rx_data, prev_rx);
        chk($sformatf("R7 R11 oe vec%0d", v), {7'd0, oe}, 8'h00);
      end
      nss_i = 1'b1;
      clear_flag();
      wait_clk(4);
    end

    // R6 double buffer: one byte loaded, one held, then empty
    nss_mode = 2'b01;
    write_tx(8'h11);
    wait_clk(3);
    write_tx(8'h22);
    nss_i = 1'b0;
    wait_clk(6);
    spi_xfer(8'hC1, 8, 1'b0, 8'h00, mi, oe);
    chk("R6 first byte", mi, 8'h11);
    spi_xfer(8'hC2, 8, 1'b0, 8'h00, mi, oe);
    chk("R6 held byte back-to-back", mi, 8'h22);
    chk("R2 rx second byte", rx_data, 8'hC2);
    spi_xfer(8'hC3, 8, 1'b0, 8'h00, mi, oe);
    chk("R5 drained sends FF", mi, 8'hFF);

    // R6 write during a byte waits for its last edge
    write_tx(8'h4B);
    wait_clk(3);
    spi_xfer(8'h10, 8, 1'b1, 8'hB4, mi, oe);
    chk("R6 current byte untouched", mi, 8'h4B);
    spi_xfer(8'h20, 8, 1'b0, 8'h00, mi, oe);
    chk("R6 mid-byte write follows", mi, 8'hB4);

    // R3 flag sticky until cleared
    wait_clk(50);
    chk("R3 flag sticky", {7'd0, done_flag}, 8'h01);
    clear_flag();
    wait_clk(2);
    chk("R3 flag cleared", {7'd0, done_flag}, 8'h00);

    // R8 aborted byte then NSS falling edge reframes
    spi_xfer(8'hE0, 3, 1'b0, 8'h00, mi, oe);
    nss_i = 1'b1;
    wait_clk(6);
    nss_i = 1'b0;
    wait_clk(6);
    spi_xfer(8'hC9, 8, 1'b0, 8'h00, mi, oe);
    chk("R8 rx after abort", rx_data, 8'hC9);
    chk("R8 flag after abort", {7'd0, done_flag}, 8'h01);
    nss_i = 1'b1;
    clear_flag();

    // R10 disabled block ignores SCK
    enable   = 1'b0;
    nss_mode = 2'b00;
    wait_clk(4);
    spi_xfer(8'h3A, 8, 1'b0, 8'h00, mi, oe);
    chk("R10 flag", {7'd0, done_flag}, 8'h00);
    chk("R10 R12 rx kept", rx_data, 8'hC9);
    chk("R10 oe", {7'd0, oe}, 8'h00);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule